// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This unit sits next to a single DMA channel engine and keeps that engine busy across a chain of transfers held in memory. Software writes the address of the first descriptor into a link pointer register. Each time the engine signals that its current transfer count has reached zero, the unit checks the link pointer. If the pointer is non-zero, the unit fetches the five-word descriptor stored at that address. It then hands the source, destination, count and control values to the engine's channel registers, adopts the descriptor's next pointer as the new link, and starts the engine again. Scattered segments therefore run one after another without software stepping in between them.

The descriptor is read over a simple word-read master port that allows any number of wait cycles per word. A null link pointer ends the chain and raises the final completion interrupt. A read error abandons the descriptor and parks the unit in an error state until software writes a new pointer.

Top module: `lld_chain_fetch`

## Requirements
- R1: After reset, eng_start, ld_valid, rd_req, chain_irq and err_flag are all low, and the link pointer is zero.
- R2: A fetch begins only when eng_done is seen while the unit is idle, the link pointer is non-zero and no error is pending. The fetch reads five words, one at a time and in order, from addresses pointer+0, +4, +8, +12 and +16 (byte addresses, 4-byte words). rd_req and rd_addr are held steady until rd_ack accepts each word, for any number of wait cycles.
- R3: The loaded descriptor is presented as a single-cycle ld_valid pulse in the cycle after the fifth word is accepted. In that pulse, ld_src, ld_dst, ld_cnt and ld_ctl carry words 0, 1, 2 and 3. The pulse never appears before all five words have been accepted.
- R4: eng_start pulses for one cycle in the cycle right after ld_valid. Word 4 of the descriptor replaces the link pointer, so descriptors run in list order.
- R5: eng_done seen while idle with a zero link pointer raises chain_irq for exactly one cycle in the following cycle, and no read is issued.
- R6: A word returned with rd_err set ends the fetch. No ld_valid or eng_start follows, and err_flag is high from the next cycle on.
- R7: While err_flag is high, eng_done is ignored: no read is issued and no chain_irq is raised. A pointer write clears err_flag and loads the pointer.
- R8: Pointer writes and eng_done arriving while a descriptor is being fetched, loaded or started have no effect on that descriptor or on the link that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ptr_we | input | 1 | Write strobe for the link pointer |
| cfg_ptr_wdata | input | AW | Link pointer value to write |
| eng_done | input | 1 | Engine reports its count reached zero |
| eng_start | output | 1 | Start pulse to the engine |
| ld_valid | output | 1 | Load strobe for the channel registers |
| ld_src | output | DW | Source address to load |
| ld_dst | output | DW | Destination address to load |
| ld_cnt | output | DW | Transfer count to load |
| ld_ctl | output | DW | Control word to load |
| rd_req | output | 1 | Word read request |
| rd_addr | output | AW | Byte address of the word being read |
| rd_ack | input | 1 | Read word accepted this cycle |
| rd_data | input | DW | Read data, valid with rd_ack |
| rd_err | input | 1 | Error response, valid with rd_ack |
| chain_irq | output | 1 | End-of-chain completion pulse |
| err_flag | output | 1 | Sticky fetch error status |

## Verification
The hardest case to reach from the ports is a pointer write or a stray eng_done that lands in the middle of a stalled descriptor fetch. Another is an error response on an inner word after some words have already been captured. For the first, the bench's memory responder inserts programmable wait cycles so the fetch stays open for several cycles, and the stimulus writes a competing pointer during that window. It then checks that both the loaded fields and the end-of-chain interrupt follow the original list. For the second, the responder flags one chosen address as failing, and the bench confirms that no load or start follows.

// File: rtl/lld_pkg.sv
package lld_pkg;
  localparam int DESC_WORDS = 5;
  localparam int W_SRC  = 0;
  localparam int W_DST  = 1;
  localparam int W_CNT  = 2;
  localparam int W_CTL  = 3;
  localparam int W_NEXT = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LOAD  = 3'd2,
    ST_START = 3'd3,
    ST_HALT  = 3'd4
  } lld_state_e;
endpackage

// File: rtl/lld_seq.sv
module lld_seq
  import lld_pkg::*;
#(
  parameter int NW    = DESC_WORDS,
  parameter int IDX_W = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_done,
  input  logic             ptr_is_null,
  input  logic             cfg_we,
  input  logic             rd_ack,
  input  logic             rd_err,
  output logic             rd_req,
  output logic [IDX_W-1:0] word_idx,
  output logic             cap_en,
  output logic             load_now,
  output logic             start_now,
  output logic             irq,
  output logic             halted,
  output logic             cfg_accept
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);

  lld_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             irq_q, irq_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    irq_d   = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (eng_done) begin
          if (ptr_is_null) begin
            irq_d = 1'b1;
          end else begin
            state_d = ST_FETCH;
            idx_d   = '0;
            idx_en  = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (rd_ack) begin
          if (rd_err) begin
            state_d = ST_HALT;
          end else begin
            cap_en = 1'b1;
            if (idx_q == LAST_IDX) begin
              state_d = ST_LOAD;
            end else begin
              idx_d  = idx_q + 1'b1;
              idx_en = 1'b1;
            end
          end
        end
      end
      ST_LOAD:  state_d = ST_START;
      ST_START: state_d = ST_IDLE;
      ST_HALT: begin
        if (cfg_we) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign rd_req     = (state_q == ST_FETCH);
  assign word_idx   = idx_q;
  assign load_now   = (state_q == ST_LOAD);
  assign start_now  = (state_q == ST_START);
  assign halted     = (state_q == ST_HALT);
  assign irq        = irq_q;
  assign cfg_accept = cfg_we && ((state_q == ST_IDLE) || (state_q == ST_HALT));
endmodule

// File: rtl/lld_shadow.sv
module lld_shadow #(
  parameter int DW    = 32,
  parameter int NW    = 5,
  parameter int IDX_W = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [IDX_W-1:0]       cap_idx,
  input  logic [DW-1:0]          cap_data,
  output logic [NW-1:0][DW-1:0]  words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic          hit;
    logic [DW-1:0] word_q;
    assign hit = cap_en && (cap_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= cap_data;
      end
    end
    assign words[g] = word_q;
  end
endmodule

// File: rtl/lld_link.sv
module lld_link #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          nxt_en,
  input  logic [AW-1:0] nxt_val,
  output logic [AW-1:0] ptr,
  output logic          is_null
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = wr_en || nxt_en;
    ptr_d  = nxt_en ? nxt_val : wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr     = ptr_q;
  assign is_null = (ptr_q == '0);
endmodule

// File: rtl/lld_chain_fetch.sv
module lld_chain_fetch
  import lld_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ptr_we,
  input  logic [AW-1:0] cfg_ptr_wdata,
  input  logic          eng_done,
  output logic          eng_start,
  output logic          ld_valid,
  output logic [DW-1:0] ld_src,
  output logic [DW-1:0] ld_dst,
  output logic [DW-1:0] ld_cnt,
  output logic [DW-1:0] ld_ctl,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          chain_irq,
  output logic          err_flag
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic                          ptr_is_null, cap_en, load_now, cfg_accept;
  logic [IDX_W-1:0]              word_idx;
  logic [AW-1:0]                 link_ptr;
  logic [DESC_WORDS-1:0][DW-1:0] words;

  lld_seq #(.NW(DESC_WORDS), .IDX_W(IDX_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .eng_done   (eng_done),
    .ptr_is_null(ptr_is_null),
    .cfg_we     (cfg_ptr_we),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .rd_req     (rd_req),
    .word_idx   (word_idx),
    .cap_en     (cap_en),
    .load_now   (load_now),
    .start_now  (eng_start),
    .irq        (chain_irq),
    .halted     (err_flag),
    .cfg_accept (cfg_accept)
  );

  lld_shadow #(.DW(DW), .NW(DESC_WORDS), .IDX_W(IDX_W)) shadow_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cap_en  (cap_en),
    .cap_idx (word_idx),
    .cap_data(rd_data),
    .words   (words)
  );

  lld_link #(.AW(AW)) link_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (cfg_accept),
    .wr_val (cfg_ptr_wdata),
    .nxt_en (load_now),
    .nxt_val(words[W_NEXT][AW-1:0]),
    .ptr    (link_ptr),
    .is_null(ptr_is_null)
  );

  always_comb begin
    rd_addr = link_ptr + (AW'(word_idx) * AW'(WORD_BYTES));
  end

  assign ld_valid = load_now;
  assign ld_src   = words[W_SRC];
  assign ld_dst   = words[W_DST];
  assign ld_cnt   = words[W_CNT];
  assign ld_ctl   = words[W_CTL];
endmodule

// File: rtl/lld_chain_fetch_chk.sv
module lld_chain_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ptr_we,
  input logic          eng_done,
  input logic          eng_start,
  input logic          ld_valid,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          rd_err,
  input logic          chain_irq,
  input logic          err_flag
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  assert_load_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(rd_ack) && !rd_req);

  assert_start_follows_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> eng_start && !ld_valid);

  assert_exclusive_phases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, ld_valid, eng_start}));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_irq |-> $past(eng_done) && !$past(rd_req) && !rd_req);

  assert_error_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack && rd_err |=> err_flag && !ld_valid && !rd_req);

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !cfg_ptr_we |=> err_flag && !chain_irq);
endmodule

bind lld_chain_fetch lld_chain_fetch_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_ptr_we(cfg_ptr_we),
  .eng_done  (eng_done),
  .eng_start (eng_start),
  .ld_valid  (ld_valid),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_ack    (rd_ack),
  .rd_err    (rd_err),
  .chain_irq (chain_irq),
  .err_flag  (err_flag)
);

// File: tb/lld_chain_fetch_tb_top.sv
module lld_chain_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ptr_we = 1'b0;
  logic [31:0] cfg_ptr_wdata = '0;
  logic        eng_done = 1'b0;
  logic        eng_start, ld_valid, rd_req, chain_irq, err_flag;
  logic [31:0] ld_src, ld_dst, ld_cnt, ld_ctl, rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_err = 1'b0;

  always #10 clk = ~clk;

  lld_chain_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ptr_we(cfg_ptr_we), .cfg_ptr_wdata(cfg_ptr_wdata),
    .eng_done(eng_done), .eng_start(eng_start), .ld_valid(ld_valid),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_ctl(ld_ctl),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .chain_irq(chain_irq), .err_flag(err_flag)
  );

  // per vector: count, wait cycles, up to three descriptor addresses in list order
  localparam logic [31:0] VEC [0:2][0:4] = '{
    '{32'd3, 32'd0, 32'h1000, 32'h1014, 32'h1028},
    '{32'd1, 32'd2, 32'h1050, 32'h0,    32'h0},
    '{32'd2, 32'd1, 32'h10A0, 32'h1078, 32'h0}
  };
  localparam logic [31:0] MEM_BASE = 32'h1000;
  localparam logic [31:0] ERR_DESC = 32'h10C8;

  logic [31:0] mem [0:63];
  int total = 0, bad = 0;
  int stall_cfg = 0, stall_cnt = 0;
  logic [31:0] exp_head = '0, err_addr = 32'hFFFF_FFFF;
  int word_n = 0, n_ld = 0, n_start = 0, n_irq = 0, n_req = 0;
  logic req_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt);
    int b;
    b = int'((a - MEM_BASE) >> 2);
    mem[b]   = 32'hA000_0000 | a;
    mem[b+1] = 32'hB000_0000 | a;
    mem[b+2] = a >> 2;
    mem[b+3] = 32'hCC00_0000 | a;
    mem[b+4] = nxt;
  endtask

  // responder and monitor, both on the falling edge
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0; rd_err = 1'b0; stall_cnt = 0; word_n++;
    end else if (rd_req) begin
      if (!req_prev) word_n = 0;
      if (stall_cnt >= stall_cfg) begin
        check(rd_addr == exp_head + 32'(word_n * 4), "R2 read address", rd_addr, exp_head + 32'(word_n * 4));
        rd_ack  = 1'b1;
        rd_err  = (rd_addr == err_addr);
        rd_data = (rd_addr >= MEM_BASE && rd_addr < MEM_BASE + 256) ? mem[(rd_addr - MEM_BASE) >> 2] : 32'h0;
      end else begin
        stall_cnt++;
      end
    end
    if (rd_req && !req_prev) n_req++;
    req_prev = rd_req;
    if (ld_valid) begin
      n_ld++;
      check(word_n == 5, "R3 words accepted before load", 32'(word_n), 32'd5);
    end
    if (eng_start) n_start++;
    if (chain_irq) n_irq++;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic write_ptr(input logic [31:0] v);
    cfg_ptr_we = 1'b1; cfg_ptr_wdata = v; tick(); cfg_ptr_we = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; tick(); eng_done = 1'b0;
  endtask

  task automatic wait_load(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (ld_valid) begin seen = 1'b1; break; end
      tick();
    end
  endtask

  task automatic check_load(input logic [31:0] a, input string tag);
    bit seen;
    wait_load(seen);
    check(seen, {tag, " load seen"}, 32'(seen), 32'd1);
    check(ld_src == (32'hA000_0000 | a), {tag, " src"}, ld_src, 32'hA000_0000 | a);
    check(ld_dst == (32'hB000_0000 | a), {tag, " dst"}, ld_dst, 32'hB000_0000 | a);
    check(ld_cnt == (a >> 2), {tag, " cnt"}, ld_cnt, a >> 2);
    check(ld_ctl == (32'hCC00_0000 | a), {tag, " ctl"}, ld_ctl, 32'hCC00_0000 | a);
    tick();
    check(eng_start && !ld_valid, "R4 start one cycle after load", {30'h0, eng_start, ld_valid}, 32'h2);
    tick();
    check(!eng_start, "R4 start is one cycle", 32'(eng_start), 32'd0);
  endtask

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = '0;
    for (int v = 0; v < 3; v++)
      for (int i = 0; i < int'(VEC[v][0]); i++)
        put_desc(VEC[v][2+i], (i + 1 < int'(VEC[v][0])) ? VEC[v][3+i] : 32'h0);
    put_desc(ERR_DESC, 32'h1000);

    repeat (3) tick();
    check({eng_start, ld_valid, rd_req, chain_irq, err_flag} == 5'b0, "R1 outputs in reset",
          {27'h0, eng_start, ld_valid, rd_req, chain_irq, err_flag}, 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    check({eng_start, ld_valid, rd_req, chain_irq, err_flag} == 5'b0, "R1 outputs after reset",
          {27'h0, eng_start, ld_valid, rd_req, chain_irq, err_flag}, 32'h0);

    // R1 R5: pointer zero after reset, so eng_done gives only an interrupt
    pulse_done();
    check(chain_irq, "R5 irq on null pointer", 32'(chain_irq), 32'd1);
    tick();
    check(!chain_irq && n_req == 0, "R5 single-cycle irq, no read", 32'(n_req), 32'd0);

    // table of chains
    for (int v = 0; v < 3; v++) begin
      int req0;
      stall_cfg = int'(VEC[v][1]);
      req0 = n_req;
      write_ptr(VEC[v][2]);
      exp_head = VEC[v][2];
      pulse_done();
      for (int i = 0; i < int'(VEC[v][0]); i++) begin
        check_load(VEC[v][2+i], "R3 R4 chain");
        if (i + 1 < int'(VEC[v][0])) exp_head = VEC[v][3+i];
        pulse_done();
      end
      check(chain_irq, "R5 irq at end of chain", 32'(chain_irq), 32'd1);
      check(n_req - req0 == int'(VEC[v][0]), "R2 one fetch per descriptor", 32'(n_req - req0), VEC[v][0]);
      tick();
    end

    // R8: competing pointer write and eng_done during a stalled fetch
    stall_cfg = 4;
    write_ptr(32'h1050);
    exp_head = 32'h1050;
    pulse_done();
    tick();
    cfg_ptr_we = 1'b1; cfg_ptr_wdata = 32'h1000; eng_done = 1'b1;
    tick();
    cfg_ptr_we = 1'b0; eng_done = 1'b0;
    check_load(32'h1050, "R8 descriptor unchanged");
    pulse_done();
    check(chain_irq, "R8 link from descriptor, not from late write", 32'(chain_irq), 32'd1);
    tick();

    // R6: error on word 2 of a descriptor
    begin
      int ld0, st0, rq0, irq0;
      stall_cfg = 1;
      err_addr = ERR_DESC + 32'd8;
      ld0 = n_ld; st0 = n_start;
      write_ptr(ERR_DESC);
      exp_head = ERR_DESC;
      pulse_done();
      repeat (20) tick();
      check(err_flag, "R6 error flag set", 32'(err_flag), 32'd1);
      check(n_ld == ld0 && n_start == st0, "R6 no load or start after error", 32'(n_ld - ld0 + n_start - st0), 32'd0);
      // R7: eng_done ignored while in error
      rq0 = n_req; irq0 = n_irq;
      pulse_done();
      repeat (5) tick();
      check(n_req == rq0 && n_irq == irq0, "R7 eng_done ignored in error", 32'(n_req - rq0 + n_irq - irq0), 32'd0);
      check(err_flag, "R7 error flag held", 32'(err_flag), 32'd1);
      err_addr = 32'hFFFF_FFFF;
      write_ptr(32'h0);
      check(!err_flag, "R7 pointer write clears error", 32'(err_flag), 32'd0);
      pulse_done();
      check(chain_irq, "R7 R5 irq after recovery with null pointer", 32'(chain_irq), 32'd1);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule